// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Resend

This block sends bytes to a smart card over one shared, half-duplex I/O line, one character at a time. Each character is a start bit, eight data bits sent least significant bit first, and an even parity bit. All bit timing comes from a parameterised elementary time unit (ETU) measured in clock cycles. After the parity bit the block releases the line for two ETUs. In that window the card can pull the line low to reject the character.

If the card rejects a character, the block raises a sticky error flag. It does not report the transfer as finished. It waits for the card to let go of the line, leaves at least two ETUs of quiet time, and then sends the same byte again. A parameter caps how many resends one byte may take. When the cap is used up, a separate retry-limit flag is raised and the byte is dropped.

A host or DMA engine writes a byte when the data-empty flag is high. The transmit interrupt, gated by its enable, signals that the byte was accepted by the card and can serve as a trigger to load the next byte. The error interrupt follows the sticky error flag, gated by its own enable.

Top module: `sc_char_tx`

## Requirements
- R1: After reset the data-empty flag is 1, and the transmit-end, error and retry-limit flags are 0. The line is driven high (`io_oe_o`=1, `io_o`=1) and both interrupt outputs are 0.
- R2: A write while the data-empty flag is 1 stores the byte and clears both the data-empty and transmit-end flags. A write while the data-empty flag is 0 is ignored, and the pending byte is the one that goes out.
- R3: While the data-empty flag is 1, the line is driven high.
- R4: A frame is ten driven ETUs of ETU_CYC cycles each: a start bit of 0, then D0 to D7 LSB first, then a parity bit that makes the count of ones in data plus parity even.
- R5: The line is released (`io_oe_o`=0) in the two ETUs after the parity bit, while waiting for a rejection to end, and during the resend gap.
- R6: The line is sampled in the middle of the first ETU after parity. A low level there sets the error flag, and `eri_o` equals `rie_i` AND the error flag.
- R7: After a rejected frame, the transmit-end flag stays 0. The same byte is resent, and its start bit begins at least 2 ETUs after the line returns high.
- R8: When a frame is not rejected, the data-empty and transmit-end flags both go to 1 at the end of the second released ETU. `txi_o` equals `tie_i` AND the transmit-end flag.
- R9: The error flag stays at 1 until `err_clr_i` is pulsed. It is not changed by a later successful frame. `err_clr_i` also clears the retry-limit flag.
- R10: If the frame sent after MAX_RETRY resends is rejected too, the retry-limit flag is set and the data-empty flag goes to 1. The transmit-end flag stays 0 and no further frame is sent.
- R11: After a completed transfer, the next frame carries the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the data register (host or DMA) |
| wr_data_i | input | 8 | Byte to send |
| err_clr_i | input | 1 | Clears the error and retry-limit flags |
| tie_i | input | 1 | Transmit interrupt enable |
| rie_i | input | 1 | Error interrupt enable |
| io_i | input | 1 | Level seen on the card I/O line, synchronous to clk_i |
| io_o | output | 1 | Level driven on the line when enabled |
| io_oe_o | output | 1 | Line output enable; 0 releases the line |
| tdre_o | output | 1 | Data register empty |
| tend_o | output | 1 | Transfer ended and accepted by the card |
| err_o | output | 1 | Sticky rejection flag |
| retry_ovf_o | output | 1 | Retry limit exceeded, byte dropped |
| txi_o | output | 1 | Transmit interrupt request |
| eri_o | output | 1 | Error interrupt request |

## Verification
The bit counter, shifter and rejection latch are internal state, and any fault in them shows on the line within one frame. A bit that is off by one, a wrong bit order or wrong parity appears in the ten mid-ETU samples of the next frame. A missed rejection sample appears at the first resend: either there is no second frame, or the transmit-end flag rises early, about 1.5 ETU after the rejection window. A wrong retry count or gap length appears as a missing or extra frame, as a retry-limit flag that is set wrongly, or as a start bit that arrives less than two ETUs after the card lets go of the line.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_HOLD  = 2'd2,
    ST_GAP   = 2'd3
  } tx_state_e;

  localparam int unsigned LAST_DRIVEN = 9;   // parity ETU
  localparam int unsigned ERR_ETU     = 10;  // rejection sample ETU
  localparam int unsigned LAST_ETU    = 11;  // second released ETU
  localparam int unsigned GAP_ETUS    = 2;

  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int unsigned ETU_CYC = 372
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic mid_o,
  output logic end_o
);
  localparam int unsigned CW   = (ETU_CYC > 2) ? $clog2(ETU_CYC) : 2;
  localparam int unsigned HALF = ETU_CYC / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (end_o)   cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign end_o = (cnt_q == CW'(ETU_CYC - 1));
  assign mid_o = (cnt_q == CW'(HALF));
endmodule

// File: rtl/sc_tx_status.sv
module sc_tx_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic       err_clr_i,
  input  logic       done_ok_i,
  input  logic       err_hit_i,
  input  logic       give_up_i,
  output logic [7:0] data_o,
  output logic       tdre_o,
  output logic       tend_o,
  output logic       err_o,
  output logic       ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      tdre_o <= 1'b1;
      tend_o <= 1'b0;
      err_o  <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      if (wr_i && tdre_o) begin
        data_o <= wr_data_i;
        tdre_o <= 1'b0;
        tend_o <= 1'b0;
      end else if (done_ok_i) begin
        tdre_o <= 1'b1;
        tend_o <= 1'b1;
      end else if (give_up_i) begin
        tdre_o <= 1'b1;
      end
      // set beats clear
      if (err_hit_i)      err_o <= 1'b1;
      else if (err_clr_i) err_o <= 1'b0;
      if (give_up_i)      ovf_o <= 1'b1;
      else if (err_clr_i) ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_tx_seq.sv
module sc_tx_seq
  import sc_tx_pkg::*;
#(
  parameter int unsigned MAX_RETRY = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pend_i,
  input  logic [7:0] data_i,
  input  logic       io_i,
  input  logic       mid_i,
  input  logic       end_i,
  output logic       timer_clr_o,
  output logic       io_o,
  output logic       io_oe_o,
  output logic       done_ok_o,
  output logic       err_hit_o,
  output logic       give_up_o
);
  localparam int unsigned RW = $clog2(MAX_RETRY + 2);

  tx_state_e     state_q;
  logic [3:0]    idx_q;
  logic [9:0]    shreg_q;
  logic          err_seen_q;
  logic [RW-1:0] retry_q;

  logic in_frame, at_err_etu, last_gap, retry_full;

  assign in_frame   = (state_q == ST_FRAME);
  assign at_err_etu = (idx_q == 4'(ERR_ETU));
  assign last_gap   = (state_q == ST_GAP) && end_i && (idx_q == 4'(GAP_ETUS - 1));
  assign retry_full = (retry_q == RW'(MAX_RETRY));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      shreg_q    <= '1;
      err_seen_q <= 1'b0;
      retry_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (pend_i) begin
          state_q    <= ST_FRAME;
          idx_q      <= '0;
          shreg_q    <= {even_par(data_i), data_i, 1'b0};
          err_seen_q <= 1'b0;
          retry_q    <= '0;
        end
        ST_FRAME: begin
          if (mid_i && at_err_etu) err_seen_q <= ~io_i;
          if (end_i) begin
            if (idx_q <= 4'(LAST_DRIVEN)) shreg_q <= {1'b1, shreg_q[9:1]};
            if (at_err_etu && err_seen_q)           state_q <= ST_HOLD;
            else if (idx_q == 4'(LAST_ETU))         state_q <= ST_IDLE;
            else                                    idx_q   <= idx_q + 1'b1;
          end
        end
        ST_HOLD: if (io_i) begin
          state_q <= ST_GAP;
          idx_q   <= '0;
        end
        ST_GAP: if (end_i) begin
          if (last_gap) begin
            if (retry_full) begin
              state_q <= ST_IDLE;
            end else begin
              retry_q    <= retry_q + 1'b1;
              state_q    <= ST_FRAME;
              idx_q      <= '0;
              shreg_q    <= {even_par(data_i), data_i, 1'b0};
              err_seen_q <= 1'b0;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign timer_clr_o = (state_q == ST_IDLE) || (state_q == ST_HOLD);
  assign io_oe_o     = (state_q == ST_IDLE) || (in_frame && idx_q <= 4'(LAST_DRIVEN));
  assign io_o        = in_frame ? shreg_q[0] : 1'b1;
  assign done_ok_o   = in_frame && end_i && (idx_q == 4'(LAST_ETU));
  assign err_hit_o   = in_frame && mid_i && at_err_etu && !io_i;
  assign give_up_o   = last_gap && retry_full;
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int unsigned ETU_CYC   = 372,
  parameter int unsigned MAX_RETRY = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wr_data_i,
  input  logic       err_clr_i,
  input  logic       tie_i,
  input  logic       rie_i,
  input  logic       io_i,
  output logic       io_o,
  output logic       io_oe_o,
  output logic       tdre_o,
  output logic       tend_o,
  output logic       err_o,
  output logic       retry_ovf_o,
  output logic       txi_o,
  output logic       eri_o
);
  logic       t_clr, t_mid, t_end;
  logic       done_ok, err_hit, give_up;
  logic [7:0] data_q;

  sc_etu_timer #(.ETU_CYC(ETU_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(t_clr),
    .mid_o(t_mid), .end_o(t_end)
  );

  sc_tx_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_i), .wr_data_i(wr_data_i), .err_clr_i(err_clr_i),
    .done_ok_i(done_ok), .err_hit_i(err_hit), .give_up_i(give_up),
    .data_o(data_q), .tdre_o(tdre_o), .tend_o(tend_o),
    .err_o(err_o), .ovf_o(retry_ovf_o)
  );

  sc_tx_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pend_i(~tdre_o), .data_i(data_q), .io_i(io_i),
    .mid_i(t_mid), .end_i(t_end), .timer_clr_o(t_clr),
    .io_o(io_o), .io_oe_o(io_oe_o),
    .done_ok_o(done_ok), .err_hit_o(err_hit), .give_up_o(give_up)
  );

  assign txi_o = tie_i & tend_o;
  assign eri_o = rie_i & err_o;
endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic err_clr_i,
  input logic io_o,
  input logic io_oe_o,
  input logic tdre_o,
  input logic tend_o,
  input logic err_o,
  input logic retry_ovf_o
);
  AST_WR_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && tdre_o |=> !tdre_o && !tend_o); // R2
  AST_TEND_FALL_BY_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tend_o) |-> $past(wr_i)); // R2
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdre_o |-> io_oe_o && io_o); // R3
  AST_RELEASED_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !io_oe_o); // R5
  AST_TEND_WITH_TDRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tend_o |-> tdre_o); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_clr_i |=> err_o); // R9
  AST_OVF_NO_TEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(retry_ovf_o) |-> tdre_o && !tend_o); // R10
endmodule

bind sc_char_tx sc_char_tx_chk u_chk (.*);

// File: tb/tb_sc_char_tx.sv
module tb_sc_char_tx;
  localparam int ETU  = 8;
  localparam int MAXR = 2;
  localparam int NVEC = 6;
  // {byte, rejections, exp_tend, exp_ovf, exp_err}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'hA5, 4'd0, 3'b100},
    {8'h3C, 4'd1, 3'b101},
    {8'hFF, 4'd2, 3'b101},
    {8'h00, 4'd0, 3'b100},
    {8'h81, 4'd3, 3'b011},
    {8'h7E, 4'd0, 3'b100}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, err_clr_i = 1'b0, tie_i = 1'b1, rie_i = 1'b1;
  logic [7:0] wr_data_i = '0;
  logic       card_n = 1'b1;
  logic       io_i, io_o, io_oe_o, tdre_o, tend_o, err_o, retry_ovf_o, txi_o, eri_o;

  assign io_i = io_oe_o ? io_o : card_n;

  sc_char_tx #(.ETU_CYC(ETU), .MAX_RETRY(MAXR)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .err_clr_i(err_clr_i), .tie_i(tie_i), .rie_i(rie_i), .io_i(io_i),
    .io_o(io_o), .io_oe_o(io_oe_o), .tdre_o(tdre_o), .tend_o(tend_o),
    .err_o(err_o), .retry_ovf_o(retry_ovf_o), .txi_o(txi_o), .eri_o(eri_o)
  );

  int checks = 0, errors = 0, cyc = 0, rel_cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); wr_i = 1'b1; wr_data_i = b;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic wait_start(input int limit, output bit found);
    found = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (io_oe_o && !io_o) begin found = 1'b1; break; end
    end
  endtask

  task automatic wait_tdre();
    for (int i = 0; i < 40 * ETU; i++) begin
      if (tdre_o) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr_i = 1'b1;
    @(negedge clk); err_clr_i = 1'b0;
  endtask

  // Observe one frame; optionally reject it; check gap after previous rejection.
  task automatic obs_frame(input logic [7:0] b, input bit inject, input bit after_rej);
    bit found;
    logic [9:0] exp, got;
    exp = {^b, b, 1'b0};
    wait_start(2000, found);
    chk(found, "R4 start", found, 1);
    if (!found) return;
    if (after_rej) chk(cyc - rel_cyc >= 2 * ETU, "R7 gap", cyc - rel_cyc, 2 * ETU);
    repeat (ETU / 2) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      if (k > 0) repeat (ETU) @(negedge clk);
      got[k] = io_oe_o ? io_o : 1'b1 ^ exp[k];
    end
    chk(got == exp, "R4 bits", got, exp);
    repeat (ETU / 2) @(negedge clk);
    if (inject) card_n = 1'b0;
    repeat (ETU / 2) @(negedge clk);
    chk(!io_oe_o, "R5 release", io_oe_o, 0);
    if (inject) begin
      repeat (ETU) @(negedge clk);
      chk(err_o == 1'b1, "R6 err", err_o, 1);
      chk(eri_o == rie_i, "R6 eri", eri_o, rie_i);
      chk(!tend_o && !tdre_o, "R7 no tend", {tend_o, tdre_o}, 0);
      chk(!io_oe_o, "R5 hold", io_oe_o, 0);
      card_n  = 1'b1;
      rel_cyc = cyc;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit found;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tdre_o && !tend_o && !err_o && !retry_ovf_o, "R1 flags",
        {tdre_o, tend_o, err_o, retry_ovf_o}, 4'b1000);
    chk(io_oe_o && io_o && !txi_o && !eri_o, "R1 line/irq",
        {io_oe_o, io_o, txi_o, eri_o}, 4'b1100);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(io_oe_o && io_o, "R3 idle high", {io_oe_o, io_o}, 2'b11);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] b;
      int nerr, nfr;
      b    = VEC[v][14:7];
      nerr = int'(VEC[v][6:3]);
      nfr  = (nerr > MAXR) ? MAXR + 1 : nerr + 1;
      write_byte(b);
      chk(!tdre_o && !tend_o, "R2 accept", {tdre_o, tend_o}, 0);
      for (int a = 0; a < nfr; a++) obs_frame(b, a < nerr, a > 0);
      wait_tdre();
      chk(tdre_o, "R8/R10 tdre", tdre_o, 1);
      chk(tend_o == VEC[v][2], "R8/R10 tend", tend_o, VEC[v][2]);
      chk(retry_ovf_o == VEC[v][1], "R10 ovf", retry_ovf_o, VEC[v][1]);
      chk(err_o == VEC[v][0], "R6 err", err_o, VEC[v][0]);
      chk(txi_o == VEC[v][2], "R8 txi", txi_o, VEC[v][2]);
      if (VEC[v][1]) begin
        wait_start(20 * ETU, found);
        chk(!found, "R10 no frame", found, 0);
      end
      pulse_clr();
      chk(!err_o && !retry_ovf_o, "R9 clear", {err_o, retry_ovf_o}, 0);
    end

    // R2: write while busy is ignored
    write_byte(8'h55);
    write_byte(8'hAA);
    obs_frame(8'h55, 1'b0, 1'b0);
    wait_tdre();
    chk(tend_o, "R8 tend", tend_o, 1);
    wait_start(20 * ETU, found);
    chk(!found, "R2 busy write dropped", found, 0);
    // R11: next frame carries the new byte
    write_byte(8'hC3);
    obs_frame(8'hC3, 1'b0, 1'b0);
    wait_tdre();

    // R9: error survives a later good frame
    write_byte(8'h5A);
    obs_frame(8'h5A, 1'b1, 1'b0);
    obs_frame(8'h5A, 1'b0, 1'b1);
    wait_tdre();
    write_byte(8'h11);
    obs_frame(8'h11, 1'b0, 1'b0);
    wait_tdre();
    chk(err_o, "R9 sticky", err_o, 1);
    rie_i = 1'b0; tie_i = 1'b0;
    @(negedge clk);
    chk(!txi_o && !eri_o, "R6/R8 enables", {txi_o, eri_o}, 0);
    pulse_clr();
    chk(!err_o, "R9 clear", err_o, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule